// File: doc/BRIEF.md
# Programmable Horizontal Sync Regenerator

This block rebuilds a clean horizontal sync pulse in the pixel clock domain. Its input is a single-cycle strobe that marks the lock edge of the incoming line sync. It emits a pulse whose width is set in pixels. The pulse either starts on the lock edge or ends on it, and it can be driven active high or active low. An enable output goes with the pulse and tells the pad whether to drive it or leave it floating.

To end a pulse on an incoming edge, the pulse must begin before that edge arrives. A counter therefore measures the length of every line between lock strobes. In the edge-ending mode, the pulse is raised when the running count reaches the last measured length minus the width. Width, mode and polarity are captured only at a lock strobe, so a pulse that is already running is never cut short or extended.

Top module: `hsync_regen`

## Requirements
- R1: `hs_oe` is 0 while `rst` is high and in the first cycle after it is released. After that, in each cycle `hs_oe` equals the inverse of the `cfg_tristate` value sampled at the previous clock edge (1 = drive, 0 = float).
- R2: In start-locked mode (`cfg_trail` = 0 captured at the last strobe) with width W > 0, the pulse is active from the cycle after the strobe edge for W cycles. If the line is shorter than W, the pulse stays active until the next strobe.
- R3: In end-locked mode (`cfg_trail` = 1) with a valid previous line length L and W < L, the pulse becomes active when the count since the last strobe reaches L − W. It stays active up to and including the cycle that carries the next strobe, and it is inactive in the cycle that follows that strobe.
- R4: End-locked mode issues no pulse until a full line has been measured. After reset, this means until the second strobe. After a strobe that changes `cfg_trail`, it means until the strobe that follows.
- R5: A captured width of 0 produces no active output in either mode.
- R6: In end-locked mode, when W ≥ L, the output is active for the whole line, from the cycle after the strobe through the next strobe cycle. It does not wrap around.
- R7: A captured `cfg_act_low` = 0 gives active-high output, and 1 gives active-low output. The inactive level is the opposite value.
- R8: `cfg_width`, `cfg_trail` and `cfg_act_low` are captured only when `lock_stb` is high. Changing them in the middle of a line does not alter the pulse of that line.
- R9: After reset, the captured width is 16, the mode is start-locked with active-high polarity, and `hs_out` stays 0 until the first strobe has been seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| lock_stb | input | 1 | One-cycle strobe at the incoming lock edge |
| cfg_width | input | WID_W | Pulse width in pixels |
| cfg_trail | input | 1 | 0 = pulse starts at lock edge, 1 = pulse ends at lock edge |
| cfg_act_low | input | 1 | 1 = active-low output |
| cfg_tristate | input | 1 | 1 = float the sync output |
| hs_out | output | 1 | Regenerated sync pulse |
| hs_oe | output | 1 | Output drive enable |

## Verification
Within a single edge, the lock strobe ends the current line and starts the next one. In that same edge, the end-locked pulse must drop, the new line length must be stored, and new width, mode and polarity must be captured. The bench provokes this by changing the configuration during every line and switching the mode at a strobe. It then compares every cycle against a model that applies the newly captured settings only from the cycle after the strobe. Lines that are shorter or longer than the prediction, and widths equal to or larger than the line, check that the end of the pulse and the capture of the new settings stay aligned.

// File: rtl/hsr_pkg.sv
package hsr_pkg;
  typedef struct packed {
    logic trail;
    logic act_low;
  } hsr_mode_t;
endpackage

// File: rtl/hsr_cfg_hold.sv
module hsr_cfg_hold #(
  parameter int WID_W     = 8,
  parameter int WIDTH_RST = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               lock_stb,
  input  logic [WID_W-1:0]   width_in,
  input  hsr_pkg::hsr_mode_t mode_in,
  output logic [WID_W-1:0]   width_nxt,
  output hsr_pkg::hsr_mode_t mode_nxt,
  output logic [WID_W-1:0]   width_q,
  output hsr_pkg::hsr_mode_t mode_q
);
  always_comb begin
    width_nxt = lock_stb ? width_in : width_q;
    mode_nxt  = lock_stb ? mode_in  : mode_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      width_q <= WID_W'(WIDTH_RST);
      mode_q  <= '0;
    end else begin
      width_q <= width_nxt;
      mode_q  <= mode_nxt;
    end
  end

  // R8: settings hold between strobes
  a_r8_hold_between: assert property (@(posedge clk) disable iff (rst)
    !lock_stb |=> ($stable(width_q) && $stable(mode_q)));
endmodule

// File: rtl/hsr_line_meter.sv
module hsr_line_meter #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lock_stb,
  input  logic             mode_chg,
  output logic [CNT_W-1:0] cnt_nxt,
  output logic [CNT_W-1:0] len_nxt,
  output logic             valid_nxt,
  output logic             seen_nxt,
  output logic [CNT_W-1:0] cnt_q,
  output logic             valid_q
);
  logic [CNT_W-1:0] len_q;
  logic             seen_q;
  logic [CNT_W-1:0] cnt_inc;

  always_comb begin
    cnt_inc   = (&cnt_q) ? cnt_q : cnt_q + 1'b1;
    cnt_nxt   = lock_stb ? '0 : cnt_inc;
    len_nxt   = lock_stb ? cnt_inc : len_q;
    valid_nxt = lock_stb ? (seen_q & ~mode_chg) : valid_q;
    seen_nxt  = seen_q | lock_stb;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      len_q   <= '0;
      valid_q <= 1'b0;
      seen_q  <= 1'b0;
    end else begin
      cnt_q   <= cnt_nxt;
      len_q   <= len_nxt;
      valid_q <= valid_nxt;
      seen_q  <= seen_nxt;
    end
  end

  // R4: no usable length before the first strobe
  a_r4_no_valid_unseen: assert property (@(posedge clk) disable iff (rst)
    !seen_q |-> !valid_q);
  // R3: line count restarts at each strobe
  a_r3_count_restart: assert property (@(posedge clk) disable iff (rst)
    lock_stb |=> (cnt_q == '0));
endmodule

// File: rtl/hsr_pulse_shaper.sv
module hsr_pulse_shaper #(
  parameter int CNT_W = 12,
  parameter int WID_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tri_in,
  input  logic [CNT_W-1:0]   cnt_nxt,
  input  logic [CNT_W-1:0]   len_nxt,
  input  logic               valid_nxt,
  input  logic               seen_nxt,
  input  logic [WID_W-1:0]   width_nxt,
  input  hsr_pkg::hsr_mode_t mode_nxt,
  output logic               sync_out,
  output logic               sync_oe
);
  localparam int PAD = CNT_W - WID_W;

  logic [CNT_W-1:0] wid_ext;
  logic [CNT_W-1:0] start_pos;
  logic             full_line;
  logic             lead_hit;
  logic             trail_hit;
  logic             act_d;

  always_comb begin
    wid_ext   = {{PAD{1'b0}}, width_nxt};
    start_pos = len_nxt - wid_ext;
    full_line = (wid_ext >= len_nxt);
    lead_hit  = (cnt_nxt < wid_ext);
    trail_hit = valid_nxt & (full_line | (cnt_nxt >= start_pos));
    act_d     = seen_nxt & (width_nxt != '0) &
                (mode_nxt.trail ? trail_hit : lead_hit);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_out <= 1'b0;
      sync_oe  <= 1'b0;
    end else begin
      sync_out <= act_d ^ mode_nxt.act_low;
      sync_oe  <= ~tri_in;
    end
  end

  // R1: output floats right after reset
  a_r1_float_after_reset: assert property (@(posedge clk)
    rst |=> !sync_oe);
endmodule

// File: rtl/hsync_regen.sv
module hsync_regen #(
  parameter int WID_W     = 8,
  parameter int CNT_W     = 12,
  parameter int WIDTH_RST = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lock_stb,
  input  logic [WID_W-1:0] cfg_width,
  input  logic             cfg_trail,
  input  logic             cfg_act_low,
  input  logic             cfg_tristate,
  output logic             hs_out,
  output logic             hs_oe
);
  hsr_pkg::hsr_mode_t mode_in, mode_nxt, mode_q;
  logic [WID_W-1:0]   width_nxt, width_q;
  logic [CNT_W-1:0]   cnt_nxt, len_nxt, cnt_q;
  logic               valid_nxt, seen_nxt, valid_q, mode_chg;

  assign mode_in.trail   = cfg_trail;
  assign mode_in.act_low = cfg_act_low;
  assign mode_chg        = (mode_nxt.trail != mode_q.trail);

  hsr_cfg_hold #(.WID_W(WID_W), .WIDTH_RST(WIDTH_RST)) u_cfg (
    .clk(clk), .rst(rst), .lock_stb(lock_stb),
    .width_in(cfg_width), .mode_in(mode_in),
    .width_nxt(width_nxt), .mode_nxt(mode_nxt),
    .width_q(width_q), .mode_q(mode_q)
  );

  hsr_line_meter #(.CNT_W(CNT_W)) u_meter (
    .clk(clk), .rst(rst), .lock_stb(lock_stb), .mode_chg(mode_chg),
    .cnt_nxt(cnt_nxt), .len_nxt(len_nxt), .valid_nxt(valid_nxt),
    .seen_nxt(seen_nxt), .cnt_q(cnt_q), .valid_q(valid_q)
  );

  hsr_pulse_shaper #(.CNT_W(CNT_W), .WID_W(WID_W)) u_shape (
    .clk(clk), .rst(rst), .tri_in(cfg_tristate),
    .cnt_nxt(cnt_nxt), .len_nxt(len_nxt), .valid_nxt(valid_nxt),
    .seen_nxt(seen_nxt), .width_nxt(width_nxt), .mode_nxt(mode_nxt),
    .sync_out(hs_out), .sync_oe(hs_oe)
  );

  // R5: zero width never shows the active level
  a_r5_zero_width_idle: assert property (@(posedge clk) disable iff (rst)
    (width_q == '0) |-> (hs_out == mode_q.act_low));
  // R4: end-locked mode is quiet without a measured line
  a_r4_trail_quiet: assert property (@(posedge clk) disable iff (rst)
    (mode_q.trail && !valid_q) |-> (hs_out == mode_q.act_low));
  // R2: start-locked pulse begins right after the strobe
  a_r2_lead_start: assert property (@(posedge clk) disable iff (rst)
    (lock_stb && !cfg_trail && (cfg_width != '0)) |=> (hs_out != $past(cfg_act_low)));
  // R3: line count is zero just after a strobe
  a_r3_cnt_zero: assert property (@(posedge clk) disable iff (rst)
    $past(lock_stb) |-> (cnt_q == '0));
endmodule

// File: tb/sim_hsync_regen.sv
module sim_hsync_regen;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       lock_stb = 1'b0;
  logic [7:0] cfg_width = 8'd16;
  logic       cfg_trail = 1'b0;
  logic       cfg_act_low = 1'b0;
  logic       cfg_tristate = 1'b1;
  logic       hs_out, hs_oe;

  always #10 clk = ~clk;

  hsync_regen u0 (
    .clk(clk), .rst(rst), .lock_stb(lock_stb), .cfg_width(cfg_width),
    .cfg_trail(cfg_trail), .cfg_act_low(cfg_act_low),
    .cfg_tristate(cfg_tristate), .hs_out(hs_out), .hs_oe(hs_oe)
  );

  bit [1:0] exp_q[$];
  string    tag_q[$];
  int       n_chk = 0;
  int       n_fail = 0;

  int m_w, m_len;
  bit m_tr, m_pol, m_seen, m_valid, m_prev_tri;

  task automatic model_reset();
    m_w = 16; m_len = 0; m_tr = 0; m_pol = 0;
    m_seen = 0; m_valid = 0; m_prev_tri = 1;
  endtask

  function automatic bit exp_act(int i);
    if (!m_seen || m_w == 0) return 1'b0;
    if (!m_tr) return (i < m_w);
    if (!m_valid) return 1'b0;
    return (m_w >= m_len) || (i >= m_len - m_w);
  endfunction

  task automatic do_reset();
    @(posedge clk); #1;
    rst = 1'b1; lock_stb = 1'b0;
    repeat (2) @(posedge clk);
    model_reset();
  endtask

  // driver: one line of p cycles, strobe in the last cycle; settings
  // given here are captured at that strobe and govern the next line
  task automatic drive_line(int p, int w, bit tr, bit pol, bit tri_b, string tag);
    for (int i = 0; i < p; i++) begin
      @(posedge clk); #1;
      rst = 1'b0;
      cfg_width = 8'(w); cfg_trail = tr; cfg_act_low = pol;
      cfg_tristate = tri_b; lock_stb = (i == p - 1);
      exp_q.push_back({exp_act(i) ^ m_pol, ~m_prev_tri});
      tag_q.push_back(tag);
      m_prev_tri = tri_b;
    end
    m_valid = (tr == m_tr) ? m_seen : 1'b0;
    m_seen = 1; m_len = p; m_w = w; m_tr = tr; m_pol = pol;
  endtask

  // monitor
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      bit [1:0] e;
      string    t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_chk += 2;
      if (hs_out !== e[1]) begin
        n_fail++;
        $display("FAIL %s hs_out got %b exp %b at %0t", t, hs_out, e[1], $time);
      end
      if (hs_oe !== e[0]) begin
        n_fail++;
        $display("FAIL R1 hs_oe got %b exp %b at %0t", hs_oe, e[0], $time);
      end
    end
  end

  initial begin
    #(20 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    do_reset();
    drive_line(20, 16, 0, 0, 1, "R9");   // reset state, floating
    drive_line(30, 5, 0, 0, 0, "R2");    // start-locked width 16
    drive_line(30, 0, 0, 0, 0, "R2");    // start-locked width 5
    drive_line(25, 7, 0, 1, 0, "R5");    // width 0: no pulse
    drive_line(25, 3, 0, 0, 0, "R7");    // active low, width 7
    drive_line(20, 8, 1, 0, 0, "R8");    // width 3 kept despite new input
    drive_line(24, 8, 1, 0, 0, "R4");    // mode just switched: quiet
    drive_line(24, 8, 1, 0, 0, "R3");    // end-locked, L=24, W=8
    drive_line(24, 30, 1, 0, 0, "R3");   // same again
    drive_line(24, 24, 1, 1, 0, "R6");   // W=30 >= L: whole line
    drive_line(24, 0, 1, 0, 0, "R6");    // W=L, active low, whole line
    drive_line(24, 5, 1, 0, 1, "R5");    // end-locked width 0, then float
    drive_line(30, 5, 0, 0, 0, "R3");    // line longer than prediction
    drive_line(20, 255, 0, 0, 0, "R2");  // start-locked width 5
    drive_line(300, 255, 0, 0, 0, "R2"); // width 255 in a long line
    drive_line(10, 16, 0, 0, 0, "R6");   // width 255 over a short line
    do_reset();
    drive_line(20, 4, 1, 0, 0, "R9");    // no strobe seen yet
    drive_line(20, 4, 1, 0, 0, "R4");    // one strobe only: quiet
    drive_line(20, 4, 1, 0, 0, "R3");    // measured: pulse 16..19
    @(negedge clk);
    @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule